// File: doc/BRIEF.md
# OTG Role Switch Sequencer

This block decides, for a dual-role USB port, whether the controller acts as a host or as a device, and it steps through the side actions that each change needs. These actions are PHY power, PHY mode, VBUS supply, the session bit, the core's host/device flag and a small OTG state report. Debounced cable events arrive on one input as a single-cycle pulse carrying a 3-bit code. Each valid code selects a fixed list of actions. The sequencer carries out that list one action per clock and holds `busy` high for as long as any work is running or waiting.

When reset is released the port is a host. The sequencer then reads two sensed levels. If the ID pin is not grounded, it runs the ID-float list. After that, if VBUS is valid, it runs the VBUS-valid list. An event that arrives while the block is busy is held in a single pending slot, and a later event replaces an earlier one in that slot. A code the block does not know leaves every output unchanged and sets a sticky error flag. If the port has no VBUS supply, the parameter `HAS_VBUS` ties the VBUS enable low.

Top module: `otg_role_seq`

## Requirements
- R1: `evt_code` is sampled when `evt_valid` is high. The codes are 1 = ID floating, 2 = ID grounded, 3 = VBUS off and 4 = VBUS valid.
- R2: ID grounded runs six actions on six consecutive clocks, in this order: PHY power on, `otg_state` to A-wait-VRISE (0), VBUS enable on, PHY mode host (`phy_host_mode`=1), session set, core host (`core_host`=1).
- R3: ID floating first clears the VBUS enable and then runs exactly the VBUS-off list. It leaves `phy_host_mode` and `core_host` unchanged.
- R4: VBUS off sets `otg_state` to B-idle (1), then clears the session bit, then removes PHY power. It does not change the VBUS enable or either mode flag.
- R5: VBUS valid powers the PHY on, then selects device PHY mode, then clears `core_host` and sets `otg_state` to device-active (2). The VBUS enable and the session bit keep their values.
- R6: Reset gives PHY power off, `phy_host_mode`=1, `core_host`=1, VBUS off, session clear, `otg_state`=0, `evt_err`=0. After reset the block runs ID floating if `sense_id_gnd` is low, then runs VBUS valid if `sense_vbus` is high. If neither applies, all outputs keep their reset values.
- R7: With `HAS_VBUS`=0, `vbus_en` stays low at all times. All other outputs behave the same as with `HAS_VBUS`=1.
- R8: `busy` is high from the clock after the accepting edge until the list finishes. That is 6 samples for ID grounded and 3 samples for VBUS valid when nothing is pending. One action completes per clock.
- R9: An event that arrives while `busy` is high waits in a one-entry slot. A newer event overwrites the slot, so only the last one runs, and it runs after the current list.
- R10: A code outside 1 to 4 changes no output and starts no action. It sets `evt_err`, which then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Single-cycle event strobe |
| evt_code | input | 3 | Event code (1..4) |
| sense_id_gnd | input | 1 | Sensed level: ID pin grounded (read only after reset) |
| sense_vbus | input | 1 | Sensed level: VBUS valid (read only after reset) |
| phy_pwr_en | output | 1 | PHY power enable |
| phy_host_mode | output | 1 | PHY mode, 1 = host, 0 = device |
| vbus_en | output | 1 | VBUS supply enable |
| session | output | 1 | Session bit |
| core_host | output | 1 | Core role, 1 = host, 0 = device |
| otg_state | output | 2 | 0 A-wait-VRISE, 1 B-idle, 2 device-active |
| busy | output | 1 | A list is running or an event is waiting |
| evt_err | output | 1 | Sticky flag for an unknown code |

## Verification
The assertions assume the following about the inputs: `evt_valid` is a clean level that is sampled only at rising edges, and the two sensed levels hold steady across reset release until both boot checks are done. They do not assume any spacing between events, because the pending slot must absorb back-to-back strobes. The stimulus changes every input only on falling edges. It holds the sensed levels fixed through each reset. It sends bursts of events while a list is running to exercise the overwrite path, and it sends unknown codes only while the block is idle, so that an unchanged output can be pinned to the bad code.

// File: rtl/otg_role_pkg.sv
package otg_role_pkg;

  localparam int CODE_W  = 3;
  localparam int STEP_W  = 3;
  localparam int STATE_W = 2;

  localparam logic [CODE_W-1:0] EV_ID_FLOAT = 3'd1;
  localparam logic [CODE_W-1:0] EV_ID_GND   = 3'd2;
  localparam logic [CODE_W-1:0] EV_VBUS_OFF = 3'd3;
  localparam logic [CODE_W-1:0] EV_VBUS_OK  = 3'd4;

  localparam logic [STATE_W-1:0] OST_A_WAIT_VRISE = 2'd0;
  localparam logic [STATE_W-1:0] OST_B_IDLE       = 2'd1;
  localparam logic [STATE_W-1:0] OST_DEV_ACTIVE   = 2'd2;

  typedef enum logic [3:0] {
    ACT_NOP,
    ACT_PHY_ON,
    ACT_PHY_OFF,
    ACT_ST_AWAIT,
    ACT_ST_BIDLE,
    ACT_VBUS_ON,
    ACT_VBUS_OFF,
    ACT_MODE_HOST,
    ACT_MODE_DEV,
    ACT_SESS_SET,
    ACT_SESS_CLR,
    ACT_CORE_HOST,
    ACT_CORE_DEV
  } act_t;

  function automatic logic code_ok(logic [CODE_W-1:0] c);
    return (c >= EV_ID_FLOAT) && (c <= EV_VBUS_OK);
  endfunction

  function automatic logic [STEP_W-1:0] list_len(logic [CODE_W-1:0] c);
    case (c)
      EV_ID_FLOAT: return 3'd4;
      EV_ID_GND:   return 3'd6;
      EV_VBUS_OFF: return 3'd3;
      EV_VBUS_OK:  return 3'd3;
      default:     return 3'd0;
    endcase
  endfunction

  // shared tail used by both the VBUS-off and the ID-float lists
  function automatic act_t voff_act(logic [STEP_W-1:0] s);
    case (s)
      3'd0:    return ACT_ST_BIDLE;
      3'd1:    return ACT_SESS_CLR;
      3'd2:    return ACT_PHY_OFF;
      default: return ACT_NOP;
    endcase
  endfunction

  function automatic act_t step_act(logic [CODE_W-1:0] c, logic [STEP_W-1:0] s);
    case (c)
      EV_ID_GND: begin
        case (s)
          3'd0:    return ACT_PHY_ON;
          3'd1:    return ACT_ST_AWAIT;
          3'd2:    return ACT_VBUS_ON;
          3'd3:    return ACT_MODE_HOST;
          3'd4:    return ACT_SESS_SET;
          3'd5:    return ACT_CORE_HOST;
          default: return ACT_NOP;
        endcase
      end
      EV_ID_FLOAT: return (s == 3'd0) ? ACT_VBUS_OFF : voff_act(s - 3'd1);
      EV_VBUS_OFF: return voff_act(s);
      EV_VBUS_OK: begin
        case (s)
          3'd0:    return ACT_PHY_ON;
          3'd1:    return ACT_MODE_DEV;
          3'd2:    return ACT_CORE_DEV;
          default: return ACT_NOP;
        endcase
      end
      default: return ACT_NOP;
    endcase
  endfunction

endpackage

// File: rtl/otg_evt_slot.sv
module otg_evt_slot
  import otg_role_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [CODE_W-1:0] evt_code,
  input  logic              direct_ok,
  input  logic              pop,
  output logic              direct_go,
  output logic              slot_valid,
  output logic [CODE_W-1:0] slot_code,
  output logic              err_flag
);

  logic good_evt;
  logic bad_evt;
  logic store;

  assign good_evt  = evt_valid && code_ok(evt_code);
  assign bad_evt   = evt_valid && !code_ok(evt_code);
  assign direct_go = good_evt && direct_ok;
  assign store     = good_evt && !direct_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_valid <= 1'b0;
      slot_code  <= '0;
      err_flag   <= 1'b0;
    end else begin
      if (store) begin
        slot_valid <= 1'b1;
        slot_code  <= evt_code;
      end else if (pop) begin
        slot_valid <= 1'b0;
      end
      if (bad_evt) err_flag <= 1'b1;
    end
  end

  assert_bad_sets_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bad_evt |=> err_flag);
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
  assert_slot_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && !pop && !store) |=> (slot_valid && $stable(slot_code)));
  assert_slot_latest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    store |=> (slot_valid && slot_code == $past(evt_code)));

endmodule

// File: rtl/otg_step_seq.sv
module otg_step_seq
  import otg_role_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] start_code,
  output logic              run,
  output logic              fire,
  output act_t              act,
  output logic [CODE_W-1:0] cur_code
);

  logic [STEP_W-1:0] step;
  logic              last;

  assign fire = run;
  assign act  = step_act(cur_code, step);
  assign last = (step == list_len(cur_code) - 3'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      step     <= '0;
      cur_code <= '0;
    end else if (run) begin
      if (last) begin
        run  <= 1'b0;
        step <= '0;
      end else begin
        step <= step + 3'd1;
      end
    end else if (start) begin
      run      <= 1'b1;
      step     <= '0;
      cur_code <= start_code;
    end
  end

  assert_one_step_per_clk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !last) |=> (run && step == $past(step) + 3'd1));
  assert_list_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && last) |=> !run);
  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> !start);

endmodule

// File: rtl/otg_out_regs.sv
module otg_out_regs
  import otg_role_pkg::*;
#(
  parameter bit HAS_VBUS = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  act_t               act,
  output logic               phy_pwr_en,
  output logic               phy_host_mode,
  output logic               vbus_en,
  output logic               session,
  output logic               core_host,
  output logic [STATE_W-1:0] otg_state
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_pwr_en    <= 1'b0;
      phy_host_mode <= 1'b1;
      session       <= 1'b0;
      core_host     <= 1'b1;
      otg_state     <= OST_A_WAIT_VRISE;
    end else if (fire) begin
      case (act)
        ACT_PHY_ON:    phy_pwr_en    <= 1'b1;
        ACT_PHY_OFF:   phy_pwr_en    <= 1'b0;
        ACT_ST_AWAIT:  otg_state     <= OST_A_WAIT_VRISE;
        ACT_ST_BIDLE:  otg_state     <= OST_B_IDLE;
        ACT_MODE_HOST: phy_host_mode <= 1'b1;
        ACT_MODE_DEV:  phy_host_mode <= 1'b0;
        ACT_SESS_SET:  session       <= 1'b1;
        ACT_SESS_CLR:  session       <= 1'b0;
        ACT_CORE_HOST: core_host     <= 1'b1;
        ACT_CORE_DEV: begin
          core_host <= 1'b0;
          otg_state <= OST_DEV_ACTIVE;
        end
        default: ;
      endcase
    end
  end

  generate
    if (HAS_VBUS) begin : g_vbus
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vbus_en <= 1'b0;
        else if (fire && act == ACT_VBUS_ON)  vbus_en <= 1'b1;
        else if (fire && act == ACT_VBUS_OFF) vbus_en <= 1'b0;
      end
    end else begin : g_no_vbus
      assign vbus_en = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/otg_role_seq.sv
module otg_role_seq
  import otg_role_pkg::*;
#(
  parameter bit HAS_VBUS = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt_valid,
  input  logic [2:0]   evt_code,
  input  logic         sense_id_gnd,
  input  logic         sense_vbus,
  output logic         phy_pwr_en,
  output logic         phy_host_mode,
  output logic         vbus_en,
  output logic         session,
  output logic         core_host,
  output logic [1:0]   otg_state,
  output logic         busy,
  output logic         evt_err
);

  localparam logic [1:0] BOOT_ID   = 2'd0;
  localparam logic [1:0] BOOT_VB   = 2'd1;
  localparam logic [1:0] BOOT_DONE = 2'd2;

  logic [1:0]        boot_st;
  logic              run;
  logic              fire;
  act_t              act;
  logic [CODE_W-1:0] cur_code;
  logic              free;
  logic              idle;
  logic              boot_go;
  logic [CODE_W-1:0] boot_code;
  logic              pop;
  logic              direct_ok;
  logic              direct_go;
  logic              slot_valid;
  logic [CODE_W-1:0] slot_code;
  logic              start;
  logic [CODE_W-1:0] start_code;

  assign free      = !run;
  assign idle      = free && (boot_st == BOOT_DONE);
  assign boot_go   = free && (((boot_st == BOOT_ID) && !sense_id_gnd) ||
                              ((boot_st == BOOT_VB) && sense_vbus));
  assign boot_code = (boot_st == BOOT_ID) ? EV_ID_FLOAT : EV_VBUS_OK;
  assign pop       = idle && slot_valid;
  assign direct_ok = idle && !slot_valid;
  assign start     = boot_go || pop || direct_go;
  assign start_code = boot_go ? boot_code : (pop ? slot_code : evt_code);
  assign busy      = run || (boot_st != BOOT_DONE) || slot_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) boot_st <= BOOT_ID;
    else if (free && boot_st != BOOT_DONE) boot_st <= boot_st + 2'd1;
  end

  otg_evt_slot u_slot (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_code(evt_code),
    .direct_ok(direct_ok), .pop(pop), .direct_go(direct_go),
    .slot_valid(slot_valid), .slot_code(slot_code), .err_flag(evt_err)
  );

  otg_step_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_code(start_code),
    .run(run), .fire(fire), .act(act), .cur_code(cur_code)
  );

  otg_out_regs #(.HAS_VBUS(HAS_VBUS)) u_out (
    .clk(clk), .rst_n(rst_n), .fire(fire), .act(act),
    .phy_pwr_en(phy_pwr_en), .phy_host_mode(phy_host_mode), .vbus_en(vbus_en),
    .session(session), .core_host(core_host), .otg_state(otg_state)
  );

  // session is only ever set after PHY power and cleared before it drops
  assert_session_needs_phy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    session |-> phy_pwr_en);
  assert_vbus_rise_in_await_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vbus_en) |-> (phy_pwr_en && otg_state == OST_A_WAIT_VRISE));
  assert_vbus_ok_keeps_supply_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cur_code == EV_VBUS_OK) |=> ($stable(vbus_en) && $stable(session)));
  assert_no_supply_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!HAS_VBUS) |-> !vbus_en);
  assert_busy_while_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid || run) |-> busy);

endmodule

// File: tb/sim_otg_role_seq.sv
`timescale 1ns/1ps
module sim_otg_role_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt_valid = 1'b0;
  logic [2:0] evt_code = 3'd0;
  logic       sense_id_gnd = 1'b1;
  logic       sense_vbus = 1'b0;
  logic       phy_pwr_en, phy_host_mode, vbus_en, session, core_host, busy, evt_err;
  logic [1:0] otg_state;
  logic       n_phy, n_host, n_vbus, n_sess, n_core, n_busy, n_err;
  logic [1:0] n_state;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  otg_role_seq u0 (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_code(evt_code),
    .sense_id_gnd(sense_id_gnd), .sense_vbus(sense_vbus),
    .phy_pwr_en(phy_pwr_en), .phy_host_mode(phy_host_mode), .vbus_en(vbus_en),
    .session(session), .core_host(core_host), .otg_state(otg_state),
    .busy(busy), .evt_err(evt_err)
  );

  otg_role_seq #(.HAS_VBUS(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_code(evt_code),
    .sense_id_gnd(sense_id_gnd), .sense_vbus(sense_vbus),
    .phy_pwr_en(n_phy), .phy_host_mode(n_host), .vbus_en(n_vbus),
    .session(n_sess), .core_host(n_core), .otg_state(n_state),
    .busy(n_busy), .evt_err(n_err)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // phy, host, vbus, sess, core, state
  task automatic check_outs(input string req, input int p, input int h, input int v,
                            input int s, input int c, input int st);
    check(req, "phy_pwr_en", phy_pwr_en, p);
    check(req, "phy_host_mode", phy_host_mode, h);
    check(req, "vbus_en", vbus_en, v);
    check(req, "session", session, s);
    check(req, "core_host", core_host, c);
    check(req, "otg_state", otg_state, st);
  endtask

  task automatic do_reset(input logic id_gnd, input logic vb);
    @(negedge clk);
    rst_n = 1'b0;
    sense_id_gnd = id_gnd;
    sense_vbus = vb;
    repeat (2) @(negedge clk);
    check_outs("R6", 0, 1, 0, 0, 1, 0);
    check("R6", "evt_err at reset", evt_err, 0);
    rst_n = 1'b1;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  // strobe lands on one rising edge; returns at the falling edge after it
  task automatic send(input logic [2:0] code);
    @(negedge clk);
    evt_valid = 1'b1;
    evt_code = code;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic t_boot_host();
    do_reset(1'b1, 1'b0);
    wait_idle();
    check_outs("R6", 0, 1, 0, 0, 1, 0);
  endtask

  task automatic t_boot_device();
    do_reset(1'b0, 1'b1);
    wait_idle();
    check_outs("R6", 1, 0, 0, 0, 0, 2);
    check("R7", "u1 phy", n_phy, 1);
    check("R7", "u1 core_host", n_core, 0);
  endtask

  task automatic t_vbus_off();
    send(3'd3);
    wait_idle();
    check_outs("R4", 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_id_gnd_order();
    int tchg[6];
    int nbusy = 0;
    logic [5:0] prev;
    logic [5:0] now;
    for (int k = 0; k < 6; k++) tchg[k] = -1;
    prev = {phy_pwr_en, (otg_state == 2'd0), vbus_en, phy_host_mode, session, core_host};
    send(3'd2);
    for (int i = 0; i < 9; i++) begin
      if (i > 0) @(negedge clk);
      if (busy) nbusy++;
      now = {phy_pwr_en, (otg_state == 2'd0), vbus_en, phy_host_mode, session, core_host};
      for (int k = 0; k < 6; k++)
        if (now[5-k] != prev[5-k] && tchg[k] < 0) tchg[k] = i;
      prev = now;
      if (i == 3) check("R7", "u1 vbus_en during ID-ground", n_vbus, 0);
    end
    for (int k = 0; k < 6; k++) check("R2", $sformatf("action %0d sample", k), tchg[k], k + 1);
    check("R8", "busy samples for ID-ground", nbusy, 6);
    check_outs("R1", 1, 1, 1, 1, 1, 0);
    check("R7", "u1 session", n_sess, 1);
  endtask

  task automatic t_vbus_ok();
    int nbusy = 0;
    send(3'd4);
    for (int i = 0; i < 6; i++) begin
      if (i > 0) @(negedge clk);
      if (busy) nbusy++;
    end
    check("R8", "busy samples for VBUS-valid", nbusy, 3);
    check_outs("R5", 1, 0, 1, 1, 0, 2);
  endtask

  task automatic t_id_float();
    send(3'd1);
    wait_idle();
    check_outs("R3", 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_overwrite();
    send(3'd2);
    evt_valid = 1'b1; evt_code = 3'd1;
    @(negedge clk);
    evt_code = 3'd4;
    @(negedge clk);
    evt_valid = 1'b0;
    check("R9", "busy while pending", busy, 1);
    wait_idle();
    check_outs("R9", 1, 0, 1, 1, 0, 2);
  endtask

  task automatic t_bad_codes();
    check("R10", "evt_err before", evt_err, 0);
    send(3'd0);
    check("R10", "busy after code 0", busy, 0);
    send(3'd5);
    send(3'd7);
    @(negedge clk);
    check("R10", "busy after bad codes", busy, 0);
    check("R10", "evt_err", evt_err, 1);
    check_outs("R10", 1, 0, 1, 1, 0, 2);
    send(3'd3);
    wait_idle();
    check("R10", "evt_err sticky", evt_err, 1);
    check_outs("R4", 0, 0, 1, 0, 0, 1);
  endtask

  initial begin
    t_boot_host();
    t_boot_device();
    t_vbus_off();
    t_id_gnd_order();
    t_vbus_ok();
    t_id_float();
    t_overwrite();
    t_bad_codes();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule